// File: doc/BRIEF.md
# Double-Buffered Segmented DAC Front End

This block is the clocked digital front end of a 14-bit multiplying converter. A host drives a parallel data word and three active-low strobes: a select, a write and a load. The word passes through two registers in series: a holding register that the select and write strobes fill, and a conversion register whose contents drive the analog switches. Because the conversion register only changes on the load strobe (or in the fully transparent mode), a host can write new words into several converters one at a time and then update all of them at once by pulsing a single shared load line.

The conversion register drives its switches in two parts. The top three bits are turned into seven equally weighted segment enables in thermometer form. The low eleven bits go straight to the binary ladder switches. A guard flag goes high whenever the conversion register holds the all-zeros code, so a gain-setting application can refuse that code.

The strobes and the data word are taken into the clock domain through a short chain of flops of equal depth, so the strobes and the data stay aligned. Each clock the block decodes the aligned strobes as levels.

Top module: `dac_front_end`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, both registers hold zero, every segment and ladder enable is 0, and the guard flag is 1.
- R2: With select low, write low and load high, the holding register takes the data word and the outputs keep their previous values.
- R3: With load low and the select/write pair not both low, the conversion register copies the holding register. The write level has no effect while select is high.
- R4: With select, write and load all low, both registers take the data word in the same clock, so the outputs follow the bus.
- R5: With load high and either select or write high, neither register changes. A later pure load shows that the holding register was left as it was.
- R6: For a code with value k (0 to 7) in bits 13..11, segment enables 0 to k-1 are 1 and the rest are 0.
- R7: Ladder enable i equals bit i of the conversion register for i = 0..10 (bit 0 is the LSB).
- R8: The guard flag is 1 exactly when all 14 bits of the conversion register are 0.
- R9: A strobe level present at a rising clock edge shows at the outputs after SYNC_STAGES+1 rising edges (3 with the default parameters), and not before.
- R10: If load goes low before write rises and stays low after write rises, the conversion register ends up holding the last word written.
- R11: Two blocks that share one load line but have separate selects update their conversion registers in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 14 | Parallel data word, bit 13 is the MSB |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write |
| ld_n | input | 1 | Active-low load of the conversion register |
| seg_en | output | 7 | Thermometer enables for the equally weighted segments |
| ladder_en | output | 11 | Binary ladder switch enables |
| zero_code | output | 1 | High while the conversion register holds all zeros |

## Verification
The properties are written on the aligned, synchronized strobe levels. They assume that the data word and the strobes reach the block together and stay at one level for at least one full clock, so that the same flop chain captures both. The stimulus meets this by changing every input only on the falling clock edge, always holding a level for at least one clock, and moving data and strobes in the same step. The shared-load case drives two blocks from one load signal. It compares them against a reference model that replays each sampled input after the synchronizer delay.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef enum logic [1:0] {
    OP_IDLE     = 2'd0,
    OP_LOAD_IN  = 2'd1,
    OP_LOAD_DAC = 2'd2,
    OP_THRU     = 2'd3
  } dacfe_op_e;

  // Strobe decode on synchronized active-low levels.
  function automatic dacfe_op_e decode_op(input logic sel_n, input logic wr_n,
                                          input logic ld_n);
    logic wr_act;
    wr_act = !sel_n && !wr_n;
    if (wr_act && !ld_n)
      return OP_THRU;
    else if (wr_act)
      return OP_LOAD_IN;
    else if (!ld_n)
      return OP_LOAD_DAC;
    else
      return OP_IDLE;
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] bus,
  output dacfe_op_e         op,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] dac_q
);

  logic [DATA_W-1:0] in_d;
  logic [DATA_W-1:0] dac_d;

  always_comb begin
    op    = decode_op(sel_n, wr_n, ld_n);
    in_d  = in_q;
    dac_d = dac_q;
    unique case (op)
      OP_LOAD_IN:  in_d = bus;
      OP_LOAD_DAC: dac_d = in_q;
      OP_THRU: begin
        in_d  = bus;
        dac_d = bus;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_d;
      dac_q <= dac_d;
    end
  end

endmodule

// File: rtl/dacfe_seg.sv
module dacfe_seg #(
  parameter int DATA_W   = 14,
  parameter int SEG_BITS = 3,
  parameter bit GUARD_EN = 1'b1,
  localparam int SEG_W    = (1 << SEG_BITS) - 1,
  localparam int LADDER_W = DATA_W - SEG_BITS
) (
  input  logic [DATA_W-1:0]   code,
  output logic [SEG_W-1:0]    seg_en,
  output logic [LADDER_W-1:0] ladder_en,
  output logic                zero_code
);

  logic [SEG_BITS-1:0] msb_val;
  assign msb_val = code[DATA_W-1 -: SEG_BITS];

  for (genvar i = 0; i < SEG_W; i++) begin : g_therm
    localparam logic [SEG_BITS-1:0] IDX = SEG_BITS'(i);
    assign seg_en[i] = (msb_val > IDX);
  end

  assign ladder_en = code[LADDER_W-1:0];

  if (GUARD_EN) begin : g_guard
    assign zero_code = (code == '0);
  end else begin : g_noguard
    assign zero_code = 1'b0;
  end

endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
  import dacfe_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int SEG_BITS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter bit GUARD_EN    = 1'b1,
  localparam int SEG_W    = (1 << SEG_BITS) - 1,
  localparam int LADDER_W = DATA_W - SEG_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   bus_data,
  input  logic                sel_n,
  input  logic                wr_n,
  input  logic                ld_n,
  output logic [SEG_W-1:0]    seg_en,
  output logic [LADDER_W-1:0] ladder_en,
  output logic                zero_code
);

  logic [2:0]        s_ctl;
  logic              s_sel_n;
  logic              s_wr_n;
  logic              s_ld_n;
  logic [DATA_W-1:0] s_bus;
  dacfe_op_e         op;
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] dac_q;

  dacfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_n, wr_n, ld_n}),
    .q     (s_ctl)
  );

  dacfe_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_data),
    .q     (s_bus)
  );

  assign s_sel_n = s_ctl[2];
  assign s_wr_n  = s_ctl[1];
  assign s_ld_n  = s_ctl[0];

  dacfe_regs #(.DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (s_sel_n),
    .wr_n  (s_wr_n),
    .ld_n  (s_ld_n),
    .bus   (s_bus),
    .op    (op),
    .in_q  (in_q),
    .dac_q (dac_q)
  );

  dacfe_seg #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .GUARD_EN(GUARD_EN)) u_seg (
    .code      (dac_q),
    .seg_en    (seg_en),
    .ladder_en (ladder_en),
    .zero_code (zero_code)
  );

endmodule

// File: rtl/dac_front_end_chk.sv
module dac_front_end_chk #(
  parameter int DATA_W   = 14,
  parameter int SEG_BITS = 3,
  parameter bit GUARD_EN = 1'b1,
  localparam int SEG_W    = (1 << SEG_BITS) - 1,
  localparam int LADDER_W = DATA_W - SEG_BITS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                s_sel_n,
  input logic                s_wr_n,
  input logic                s_ld_n,
  input logic [DATA_W-1:0]   s_bus,
  input logic [DATA_W-1:0]   in_q,
  input logic [DATA_W-1:0]   dac_q,
  input logic [SEG_W-1:0]    seg_en,
  input logic [LADDER_W-1:0] ladder_en,
  input logic                zero_code
);

  // R2
  load_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_sel_n && !s_wr_n && s_ld_n) |=> (in_q == $past(s_bus)) && $stable(dac_q));

  // R3
  load_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ld_n && (s_sel_n || s_wr_n)) |=> (dac_q == $past(in_q)) && $stable(in_q));

  // R4
  thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_sel_n && !s_wr_n && !s_ld_n) |=> (dac_q == $past(s_bus)) && (in_q == $past(s_bus)));

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ld_n && (s_sel_n || s_wr_n)) |=> $stable(in_q) && $stable(dac_q));

  // R6
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_en & SEG_W'(seg_en + 1'b1)) == '0) &&
    ($countones(seg_en) == int'(dac_q[DATA_W-1 -: SEG_BITS])));

  // R8
  guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GUARD_EN && zero_code) |-> (ladder_en == '0) && (seg_en == '0));

endmodule

bind dac_front_end dac_front_end_chk #(
  .DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .GUARD_EN(GUARD_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_sel_n   (s_sel_n),
  .s_wr_n    (s_wr_n),
  .s_ld_n    (s_ld_n),
  .s_bus     (s_bus),
  .in_q      (in_q),
  .dac_q     (dac_q),
  .seg_en    (seg_en),
  .ladder_en (ladder_en),
  .zero_code (zero_code)
);

// File: tb/sim_dac_front_end.sv
`timescale 1ns/1ps
module sim_dac_front_end;

  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_data = '0;
  logic        sel0_n = 1'b1;
  logic        sel1_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        ld_n = 1'b1;

  logic [6:0]  seg0, seg1;
  logic [10:0] lad0, lad1;
  logic        zr0, zr1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_front_end #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .sel_n(sel0_n),
    .wr_n(wr_n), .ld_n(ld_n), .seg_en(seg0), .ladder_en(lad0), .zero_code(zr0));

  dac_front_end #(.SYNC_STAGES(SYNC)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .sel_n(sel1_n),
    .wr_n(wr_n), .ld_n(ld_n), .seg_en(seg1), .ladder_en(lad1), .zero_code(zr1));

  // Expected output views of a 14-bit code.
  function automatic logic [6:0] exp_seg(input logic [13:0] c);
    int k;
    k = int'(c) / 2048;
    return 7'((1 << k) - 1);
  endfunction

  function automatic logic [10:0] exp_lad(input logic [13:0] c);
    return 11'(int'(c) % 2048);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_code0(input string tag, input logic [13:0] c);
    chk({tag, " seg"}, 32'(seg0), 32'(exp_seg(c)));
    chk({tag, " ladder"}, 32'(lad0), 32'(exp_lad(c)));
    chk({tag, " zero"}, 32'(zr0), 32'(c == 14'd0));
  endtask

  task automatic chk_code1(input string tag, input logic [13:0] c);
    chk({tag, " seg u1"}, 32'(seg1), 32'(exp_seg(c)));
    chk({tag, " ladder u1"}, 32'(lad1), 32'(exp_lad(c)));
    chk({tag, " zero u1"}, 32'(zr1), 32'(c == 14'd0));
  endtask

  // Reference model: behavioural, replays inputs after the sync delay.
  logic [16:0] q0[$];
  logic [16:0] q1[$];
  logic [13:0] in_m[2];
  logic [13:0] dac_m[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      q0.delete();
      q1.delete();
      for (int i = 0; i < SYNC; i++) begin
        q0.push_back({3'b111, 14'd0});
        q1.push_back({3'b111, 14'd0});
      end
      for (int d = 0; d < 2; d++) begin
        in_m[d]  = '0;
        dac_m[d] = '0;
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        logic [16:0] e;
        bit wa;
        e = (d == 0) ? q0.pop_front() : q1.pop_front();
        wa = !e[16] && !e[15];
        if (wa) in_m[d] = e[13:0];
        if (!e[14]) dac_m[d] = in_m[d];
      end
      q0.push_back({sel0_n, wr_n, ld_n, bus_data});
      q1.push_back({sel1_n, wr_n, ld_n, bus_data});
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 model seg u0", 32'(seg0), 32'(exp_seg(dac_m[0])));
      chk("R7 model ladder u0", 32'(lad0), 32'(exp_lad(dac_m[0])));
      chk("R8 model zero u0", 32'(zr0), 32'(dac_m[0] == 14'd0));
      chk("R11 model seg u1", 32'(seg1), 32'(exp_seg(dac_m[1])));
      chk("R11 model ladder u1", 32'(lad1), 32'(exp_lad(dac_m[1])));
    end
  end

  task automatic drive(input logic s0, input logic s1, input logic w,
                       input logic l, input logic [13:0] d);
    @(negedge clk);
    sel0_n = s0; sel1_n = s1; wr_n = w; ld_n = l; bus_data = d;
  endtask

  // Return strobes to idle and wait until the pulse has reached the outputs.
  task automatic settle();
    @(negedge clk);
    sel0_n = 1'b1; sel1_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
    repeat (SYNC) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_code0("R1 reset", 14'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_code0("R1 after release", 14'd0);

    // R2: capture into holding register only
    drive(1'b0, 1'b1, 1'b0, 1'b1, 14'h2ABC);
    settle();
    chk_code0("R2 outputs held", 14'd0);

    // R3: load with select high, write low is ignored
    drive(1'b1, 1'b1, 1'b0, 1'b0, 14'h0155);
    settle();
    chk_code0("R3 load", 14'h2ABC);
    chk_code1("R3 other untouched", 14'd0);

    // R4: transparent
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h3FFF);
    settle();
    chk_code0("R4 thru", 14'h3FFF);

    // R5: no-op forms, then a pure load shows holding register unchanged
    drive(1'b1, 1'b1, 1'b0, 1'b1, 14'h1234);
    settle();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 14'h0001);
    settle();
    chk_code0("R5 idle outputs", 14'h3FFF);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 14'h0002);
    settle();
    chk_code0("R5 holding kept", 14'h3FFF);

    // R6 / R7: thermometer and ladder sweep
    for (int k = 0; k < 8; k++) begin
      logic [13:0] c;
      c = {3'(k), 11'((k * 37 + 5) % 2048)};
      drive(1'b0, 1'b1, 1'b0, 1'b0, c);
      settle();
      chk_code0("R6 R7 sweep", c);
    end

    // R8: all-zeros guard
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h0000);
    settle();
    chk_code0("R8 zero code", 14'h0000);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h0001);
    settle();
    chk("R8 one code", 32'(zr0), 32'd0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h0000);
    settle();

    // R9: latency of a load pulse
    drive(1'b0, 1'b1, 1'b0, 1'b1, 14'h0800);
    settle();
    drive(1'b1, 1'b1, 1'b1, 1'b0, 14'h0000);
    @(negedge clk);
    ld_n = 1'b1;
    chk_code0("R9 edge1 old", 14'h0000);
    @(negedge clk);
    chk_code0("R9 edge2 old", 14'h0000);
    @(negedge clk);
    chk_code0("R9 edge3 new", 14'h0800);

    // R10: load held across the end of write
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h0AAA);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h1555);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 14'h1555);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 14'h3C3C);
    settle();
    chk_code0("R10 final word", 14'h1555);

    // R11: separate writes, shared load
    drive(1'b0, 1'b1, 1'b0, 1'b1, 14'h0123);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 14'h3210);
    settle();
    chk_code0("R11 u0 before", 14'h1555);
    chk_code1("R11 u1 before", 14'h0000);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 14'h0000);
    @(negedge clk);
    ld_n = 1'b1;
    @(negedge clk);
    chk_code0("R11 u0 edge2", 14'h1555);
    chk_code1("R11 u1 edge2", 14'h0000);
    @(negedge clk);
    chk_code0("R11 u0 edge3", 14'h0123);
    chk_code1("R11 u1 edge3", 14'h3210);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule